// File: doc/BRIEF.md
# Zero-Page Pointer Capture Snooper

This block sits beside an 8-bit processor bus and watches it one bus cycle at a time. Two reserved opcode bytes are recognised during opcode fetches. When one of them appears, the block replaces it on the processor's data input with an ordinary indexed-indirect opcode: A1h for the load form and 81h for the store form. The processor then runs a normal instruction.

The sequencer counts the bus cycles of that instruction. On the fourth cycle it copies the byte the processor reads into the low byte of a 16-bit pointer register W. On the fifth cycle it copies the next byte into the high byte. No bus cycle is added. The processor's own accumulator only ever sees the normal load result.

W is mapped read-only at two adjacent zero-page addresses, low byte first, so a later indirect-indexed-by-Y instruction can use it as its pointer. While one of those addresses is read, the block drives the W byte and raises a select that disables the memory behind it. The clock enable marks the cycles in which a bus cycle completes. The block runs on the fast clock, and a bus cycle may span several clocks.

Top module: `ptrcap_snoop`

## Requirements
- R1: Synchronous active-high reset clears W to 0000h and returns the sequencer to idle.
- R2: A read with SYNC high whose byte is CBh is presented to the processor as A1h in the same cycle, with the drive select high.
- R3: A read with SYNC high whose byte is 8Bh is presented as 81h in the same cycle, with the drive select high.
- R4: Any other opcode fetch, and any non-SYNC read of CBh or 8Bh outside the W pair, passes the memory byte through with the drive select low. A SYNC cycle with an ordinary opcode ends any sequence in progress without a capture.
- R5: Bus cycles 2 and 3 of a substituted instruction leave W unchanged.
- R6: The byte the processor receives in bus cycle 4 is in W[7:0] after that cycle completes.
- R7: The byte the processor receives in bus cycle 5 is in W[15:8] after that cycle completes.
- R8: Bus cycle 6 passes through unchanged, W holds, and the sequencer is idle afterwards, so no cycle is added.
- R9: A read of 00F0h returns W[7:0] and a read of 00F1h returns W[15:8], with the drive select high. Writes to either address are not driven and do not alter W.
- R10: When a pointer byte lies in the W pair, the value captured is the W byte the processor received, not the memory byte.
- R11: Clocks with the clock enable low do not advance the sequencer and do not capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce | input | 1 | High in the clock where a bus cycle completes |
| bus_addr | input | 16 | Processor address |
| mem_rdata | input | 8 | Byte returned by memory |
| bus_sync | input | 1 | High during an opcode fetch |
| bus_rnw | input | 1 | High for a read, low for a write |
| cpu_rdata | output | 8 | Byte presented to the processor |
| blk_drive | output | 1 | High when the block supplies the byte and memory is disabled |
| w_value | output | 16 | Current W register contents |

## Verification
The hardest case to reach is a pointer whose bytes fall on the W pair itself. There, the capture path and the read-mapping path act on the same register in the same cycle. The stimulus places the zero-page pointer at 00EFh, so the high byte is read from 00F0h and W must take its own old low byte into its high half. Clock-enable stalls inside a capture window, and a SYNC cycle that cuts a sequence short, are also driven as explicit bus scripts. A behavioural model tracks the cycle count and W every clock.

// File: rtl/ptrcap_pkg.sv
package ptrcap_pkg;
  localparam int unsigned BUS_DW = 8;
  localparam int unsigned BUS_AW = 16;

  // reserved opcode bytes and their standard replacements
  localparam logic [BUS_DW-1:0] OPC_LOAD_SPECIAL  = 8'hCB;
  localparam logic [BUS_DW-1:0] OPC_STORE_SPECIAL = 8'h8B;
  localparam logic [BUS_DW-1:0] OPC_LOAD_XIND     = 8'hA1;
  localparam logic [BUS_DW-1:0] OPC_STORE_XIND    = 8'h81;

  // bus cycle index (counted from 0 after the fetch) of the first pointer read
  localparam int unsigned PTR_FIRST_CYCLE = 3;
  localparam int unsigned PTR_BYTES       = 2;

  localparam logic [BUS_AW-1:0] W_MAP_BASE = 16'h00F0;
endpackage

// File: rtl/ptrcap_decode.sv
module ptrcap_decode #(
  parameter int unsigned           DATA_W  = 8,
  parameter int unsigned           ADDR_W  = 16,
  parameter int unsigned           NBYTES  = 2,
  parameter logic [ADDR_W-1:0]     MAP_BASE = 16'h00F0,
  parameter logic [DATA_W-1:0]     OP_LD   = 8'hCB,
  parameter logic [DATA_W-1:0]     OP_ST   = 8'h8B,
  parameter logic [DATA_W-1:0]     SUB_LD  = 8'hA1,
  parameter logic [DATA_W-1:0]     SUB_ST  = 8'h81
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        mem_byte,
  input  logic                     sync,
  input  logic                     rnw,
  input  logic [NBYTES*DATA_W-1:0] w_q,
  output logic [DATA_W-1:0]        out_byte,
  output logic                     drive,
  output logic                     special
);
  logic [NBYTES-1:0] map_hit;
  logic [DATA_W-1:0] src_byte;
  logic              any_hit;
  logic              is_ld, is_st;

  // one address comparator per W byte
  for (genvar g = 0; g < NBYTES; g++) begin : g_map
    localparam logic [ADDR_W-1:0] BYTE_ADDR = MAP_BASE + ADDR_W'(g);
    assign map_hit[g] = rnw && (addr == BYTE_ADDR);
  end

  assign any_hit = |map_hit;

  always_comb begin
    src_byte = mem_byte;
    for (int i = 0; i < NBYTES; i++) begin
      if (map_hit[i]) src_byte = w_q[i*DATA_W +: DATA_W];
    end
  end

  assign is_ld   = sync && rnw && (src_byte == OP_LD);
  assign is_st   = sync && rnw && (src_byte == OP_ST);
  assign special = is_ld || is_st;

  always_comb begin
    if (is_ld)      out_byte = SUB_LD;
    else if (is_st) out_byte = SUB_ST;
    else            out_byte = src_byte;
  end

  assign drive = any_hit || special;
endmodule

// File: rtl/ptrcap_seq.sv
module ptrcap_seq #(
  parameter int unsigned FIRST  = 3,
  parameter int unsigned NBYTES = 2,
  parameter int unsigned LAST   = FIRST + NBYTES,
  parameter int unsigned CNT_W  = $clog2(LAST + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             sync,
  input  logic             special,
  output logic [CNT_W-1:0] cnt,
  output logic [NBYTES-1:0] cap_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ce) begin
      if (sync)                                     cnt <= special ? CNT_W'(1) : '0;
      else if (cnt != '0 && cnt < CNT_W'(LAST))     cnt <= cnt + CNT_W'(1);
      else                                          cnt <= '0;
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_cap
    assign cap_en[g] = ce && !sync && (cnt == CNT_W'(FIRST + g));
  end
endmodule

// File: rtl/ptrcap_wreg.sv
module ptrcap_wreg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NBYTES-1:0]        cap_en,
  input  logic [DATA_W-1:0]        cap_byte,
  output logic [NBYTES*DATA_W-1:0] w_q
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)            w_q[g*DATA_W +: DATA_W] <= '0;
      else if (cap_en[g]) w_q[g*DATA_W +: DATA_W] <= cap_byte;
    end
  end
endmodule

// File: rtl/ptrcap_snoop.sv
module ptrcap_snoop
  import ptrcap_pkg::*;
#(
  parameter int unsigned       DATA_W   = BUS_DW,
  parameter int unsigned       ADDR_W   = BUS_AW,
  parameter int unsigned       NBYTES   = PTR_BYTES,
  parameter int unsigned       FIRST    = PTR_FIRST_CYCLE,
  parameter logic [ADDR_W-1:0] MAP_BASE = W_MAP_BASE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_ce,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     bus_sync,
  input  logic                     bus_rnw,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     blk_drive,
  output logic [NBYTES*DATA_W-1:0] w_value
);
  localparam int unsigned LAST  = FIRST + NBYTES;
  localparam int unsigned CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0]  seq_cnt;
  logic [NBYTES-1:0] cap_en;
  logic              special;

  ptrcap_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBYTES(NBYTES), .MAP_BASE(MAP_BASE),
    .OP_LD(OPC_LOAD_SPECIAL), .OP_ST(OPC_STORE_SPECIAL),
    .SUB_LD(OPC_LOAD_XIND), .SUB_ST(OPC_STORE_XIND)
  ) u_decode (
    .addr(bus_addr), .mem_byte(mem_rdata), .sync(bus_sync), .rnw(bus_rnw),
    .w_q(w_value), .out_byte(cpu_rdata), .drive(blk_drive), .special(special)
  );

  ptrcap_seq #(
    .FIRST(FIRST), .NBYTES(NBYTES), .LAST(LAST), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .ce(bus_ce), .sync(bus_sync), .special(special),
    .cnt(seq_cnt), .cap_en(cap_en)
  );

  // capture what the processor actually receives, mapped W bytes included
  ptrcap_wreg #(
    .DATA_W(DATA_W), .NBYTES(NBYTES)
  ) u_wreg (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_byte(cpu_rdata), .w_q(w_value)
  );
endmodule

// File: rtl/ptrcap_snoop_chk.sv
module ptrcap_snoop_chk #(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       FIRST    = 3,
  parameter int unsigned       CNT_W    = 3,
  parameter logic [ADDR_W-1:0] MAP_BASE = 16'h00F0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_ce,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     mem_rdata,
  input logic                  bus_sync,
  input logic                  bus_rnw,
  input logic [DATA_W-1:0]     cpu_rdata,
  input logic                  blk_drive,
  input logic [2*DATA_W-1:0]   w_value,
  input logic [CNT_W-1:0]      seq_cnt
);
  logic in_map, cap_lo, cap_hi;
  assign in_map = (bus_addr == MAP_BASE) || (bus_addr == MAP_BASE + ADDR_W'(1));
  assign cap_lo = bus_ce && !bus_sync && (seq_cnt == CNT_W'(FIRST));
  assign cap_hi = bus_ce && !bus_sync && (seq_cnt == CNT_W'(FIRST + 1));

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (w_value == '0 && seq_cnt == '0)); // R1

  AST_LOAD_SUBST: assert property (@(posedge clk) disable iff (rst)
    (bus_sync && bus_rnw && !in_map && mem_rdata == 8'hCB) |-> (cpu_rdata == 8'hA1 && blk_drive)); // R2

  AST_STORE_SUBST: assert property (@(posedge clk) disable iff (rst)
    (bus_sync && bus_rnw && !in_map && mem_rdata == 8'h8B) |-> (cpu_rdata == 8'h81 && blk_drive)); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!bus_sync && !in_map) |-> (cpu_rdata == mem_rdata && !blk_drive)); // R4

  AST_NO_STRAY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !(cap_lo || cap_hi) |=> $stable(w_value)); // R5

  AST_CAPTURE_LOW: assert property (@(posedge clk) disable iff (rst)
    cap_lo |=> (w_value[DATA_W-1:0] == $past(cpu_rdata))); // R6

  AST_CAPTURE_HIGH: assert property (@(posedge clk) disable iff (rst)
    cap_hi |=> (w_value[2*DATA_W-1:DATA_W] == $past(cpu_rdata))); // R7

  AST_MAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (bus_rnw && !bus_sync && bus_addr == MAP_BASE) |-> (blk_drive && cpu_rdata == w_value[DATA_W-1:0])); // R9

  AST_MAP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (bus_rnw && !bus_sync && bus_addr == MAP_BASE + ADDR_W'(1)) |-> (blk_drive && cpu_rdata == w_value[2*DATA_W-1:DATA_W])); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_ce |=> ($stable(seq_cnt) && $stable(w_value))); // R11
endmodule

bind ptrcap_snoop ptrcap_snoop_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIRST(FIRST), .CNT_W(CNT_W), .MAP_BASE(MAP_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_ce(bus_ce), .bus_addr(bus_addr), .mem_rdata(mem_rdata),
  .bus_sync(bus_sync), .bus_rnw(bus_rnw), .cpu_rdata(cpu_rdata), .blk_drive(blk_drive),
  .w_value(w_value), .seq_cnt(seq_cnt)
);

// File: tb/ptrcap_snoop_tb.sv
module ptrcap_snoop_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_ce = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  mem_rdata = '0;
  logic        bus_sync = 1'b0;
  logic        bus_rnw = 1'b1;
  logic [7:0]  cpu_rdata;
  logic        blk_drive;
  logic [15:0] w_value;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] m_w = '0;
  int          m_phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptrcap_snoop u_dut (
    .clk(clk), .rst(rst), .bus_ce(bus_ce), .bus_addr(bus_addr), .mem_rdata(mem_rdata),
    .bus_sync(bus_sync), .bus_rnw(bus_rnw), .cpu_rdata(cpu_rdata), .blk_drive(blk_drive),
    .w_value(w_value)
  );

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic s,
                      input logic r, input logic c, input string req);
    logic [7:0] raw, exp_d;
    logic       exp_drv, spec;
    @(negedge clk);
    bus_addr = a; mem_rdata = d; bus_sync = s; bus_rnw = r; bus_ce = c;
    #1;
    raw = d; exp_drv = 1'b0;
    if (r && a == 16'h00F0) begin raw = m_w[7:0];  exp_drv = 1'b1; end
    if (r && a == 16'h00F1) begin raw = m_w[15:8]; exp_drv = 1'b1; end
    exp_d = raw; spec = 1'b0;
    if (s && r && raw == 8'hCB) begin exp_d = 8'hA1; spec = 1'b1; end
    if (s && r && raw == 8'h8B) begin exp_d = 8'h81; spec = 1'b1; end
    if (spec) exp_drv = 1'b1;
    compared++;
    if (cpu_rdata !== exp_d || blk_drive !== exp_drv || w_value !== m_w) begin
      mismatched++;
      $display("FAIL %s: data=%h drive=%b w=%h expected data=%h drive=%b w=%h",
               req, cpu_rdata, blk_drive, w_value, exp_d, exp_drv, m_w);
    end
    @(posedge clk);
    if (c) begin
      if (!s && m_phase == 3) m_w[7:0]  = exp_d;
      if (!s && m_phase == 4) m_w[15:8] = exp_d;
      if (s)                              m_phase = spec ? 1 : 0;
      else if (m_phase != 0 && m_phase < 5) m_phase = m_phase + 1;
      else                                m_phase = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_ce = 1'b0; bus_sync = 1'b0; bus_rnw = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_w = '0; m_phase = 0;
  endtask

  // full special instruction: fetch, operand, dead, ptr lo, ptr hi, data access
  task automatic run_special(input logic [7:0] op, input logic [15:0] ptr_at,
                             input logic [7:0] lo, input logic [7:0] hi,
                             input bit stall, input string tag);
    step(16'h0400, op, 1, 1, 1, tag);
    step(16'h0401, ptr_at[7:0], 0, 1, 1, "R5");
    if (stall) step(16'h0401, 8'h33, 0, 1, 0, "R11");
    step(16'h0401, 8'h77, 0, 1, 1, "R5");
    step(ptr_at, lo, 0, 1, 1, "R6");
    if (stall) step(ptr_at, 8'h44, 0, 1, 0, "R11");
    step(ptr_at + 16'd1, hi, 0, 1, 1, "R7");
    step({hi, lo}, 8'h5A, 0, (op == 8'h8B) ? 1'b0 : 1'b1, 1, "R8");
  endtask

  initial begin
    do_reset();
    step(16'h0200, 8'h00, 0, 1, 1, "R1");

    run_special(8'hCB, 16'h0010, 8'h34, 8'h12, 0, "R2");
    step(16'h0402, 8'hEA, 1, 1, 1, "R8");
    step(16'h0403, 8'h11, 0, 1, 1, "R8");

    run_special(8'h8B, 16'h0020, 8'h78, 8'h56, 1, "R3");
    step(16'h0410, 8'hEA, 1, 1, 1, "R8");

    // real indexed-indirect opcode is not special
    step(16'h0500, 8'hA1, 1, 1, 1, "R4");
    step(16'h0501, 8'h30, 0, 1, 1, "R4");
    step(16'h0501, 8'h00, 0, 1, 1, "R4");
    step(16'h0030, 8'hAA, 0, 1, 1, "R4");
    step(16'h0031, 8'hBB, 0, 1, 1, "R4");
    step(16'h0300, 8'hCB, 0, 1, 1, "R4");
    step(16'h0301, 8'h8B, 0, 1, 1, "R4");

    // W map reads and ignored writes
    step(16'h00F0, 8'h99, 0, 1, 1, "R9");
    step(16'h00F1, 8'h98, 0, 1, 1, "R9");
    step(16'h00F0, 8'h01, 0, 0, 1, "R9");
    step(16'h00F1, 8'h02, 0, 0, 1, "R9");
    step(16'h00F0, 8'h97, 0, 1, 1, "R9");

    // pointer straddles into W pair: hi byte comes from W low
    run_special(8'hCB, 16'h00EF, 8'hC4, 8'hEE, 0, "R10");
    step(16'h00F0, 8'h00, 0, 1, 1, "R10");
    step(16'h00F1, 8'h00, 0, 1, 1, "R10");

    // abort by a SYNC where the low pointer byte was due
    step(16'h0600, 8'hCB, 1, 1, 1, "R4");
    step(16'h0601, 8'h40, 0, 1, 1, "R4");
    step(16'h0601, 8'h00, 0, 1, 1, "R4");
    step(16'h0602, 8'hEA, 1, 1, 1, "R4");
    step(16'h0603, 8'h21, 0, 1, 1, "R4");
    step(16'h0604, 8'h22, 0, 1, 1, "R4");
    step(16'h0605, 8'h23, 0, 1, 1, "R4");

    // many stalled clocks inside the sequence
    step(16'h0700, 8'hCB, 1, 1, 1, "R11");
    for (int k = 0; k < 5; k++) step(16'h0701, 8'h50, 0, 1, 0, "R11");
    run_special(8'hCB, 16'h0050, 8'h0F, 8'hF0, 1, "R11");

    do_reset();
    step(16'h0200, 8'h00, 0, 1, 1, "R1");
    step(16'h00F0, 8'h55, 0, 1, 1, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule